// File: doc/BRIEF.md
# Power-Down Request Qualification Timer

This block stands between a function that asks to be powered down and the interrupt that reports the request to the host. A request reaches the interrupt only after it has been held without a break for an interval chosen by a 3-bit filter code. That code normally comes from a control register. The interval is counted in whole seconds. A free-running prescaler divides the system clock into a one-second tick.

Filter code 000 turns the path off. Codes 001, 010 and 011 select a short, medium or long interval, with defaults of 4, 129 and 518 seconds. Any code whose top bit is set passes the request on at once.

Once raised, the interrupt holds until the request is withdrawn or software pulses the clear input. A status output shows when a qualification interval is in progress. The number of clock cycles in one tick is a parameter, so a testbench can shrink the time base and still cover the long intervals.

Top module: `pdf_filter_top`

## Requirements
- R1: After reset, `pd_irq_o` and `pd_busy_o` are both 0, and the internally held filter code is 000.
- R2: While `filt_code_i` is 000, `pd_irq_o` is 0 one cycle later, whatever `pd_req_i` does, and `pd_busy_o` stays 0.
- R3: A tick is produced once every `TICK_CYCLES` clock cycles, free-running from reset. With code 001 and N = `SECS_SHORT`, a request held from cycle 0 (the first edge that sees it) raises `pd_irq_o` no earlier than after (N-1)*TICK_CYCLES+2 edges and no later than after N*TICK_CYCLES+1 edges.
- R4: Code 010 behaves as in R3 with N = `SECS_MID`, and code 011 with N = `SECS_LONG`.
- R5: With any code in which bit 2 is 1, a request raises `pd_irq_o` one clock edge after the edge that first sees it.
- R6: When `pd_req_i` goes low, `pd_irq_o` and `pd_busy_o` are 0 one cycle later. The count is then discarded, so a renewed request must again be held for the full interval of R3 or R4.
- R7: A change of `filt_code_i` while a request is held restarts the count from zero under the new code. The interrupt then rises within the R3/R4 window for the new code, shifted by one cycle.
- R8: A pulse on `irq_clr_i` makes `pd_irq_o` 0 one cycle later. It stays 0 while the same request remains held, until the request is withdrawn and raised again.
- R9: `pd_busy_o` is 1 from one cycle after a request is seen with code 001 to 011 until the interrupt is raised. It is never 1 together with `pd_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Power-down request from the function |
| filt_code_i | input | 3 | Filter code: 000 off, 001/010/011 timed, 1xx immediate |
| irq_clr_i | input | 1 | Single-cycle pulse that clears the interrupt |
| pd_irq_o | output | 1 | Qualified power-down interrupt |
| pd_busy_o | output | 1 | A qualification interval is in progress |

## Verification
The tick phase runs freely, so a timed interrupt is due inside a window of one tick period. The bench samples on the falling edge after the lower bound to confirm the interrupt is still low, and after the upper bound to confirm it is high. The start cycle is swept across every tick phase for each timed code. Immediate mode, clear, request drop and busy are each due exactly one edge after their stimulus, and each is sampled on the falling edge that follows that single edge.

// File: rtl/pdf_pkg.sv
`timescale 1ns/1ps
package pdf_pkg;

    // codes 001..011 select a timed interval
    function automatic logic is_timed(input logic [2:0] code);
        return (code[2] == 1'b0) && (code[1:0] != 2'b00);
    endfunction

    // top bit set: request passes at once
    function automatic logic is_bypass(input logic [2:0] code);
        return code[2];
    endfunction

endpackage

// File: rtl/pdf_tickgen.sv
`timescale 1ns/1ps
module pdf_tickgen #(
    parameter int TICK_CYCLES = 200_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (TICK_CYCLES <= 1) begin : g_every_cycle
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

            typedef struct packed {
                logic [PW-1:0] pre;
                logic          tick;
            } tg_t;

            tg_t tg_d, tg_q;

            always_comb begin
                tg_d = tg_q;
                if (tg_q.pre == LAST) begin
                    tg_d.pre  = '0;
                    tg_d.tick = 1'b1;
                end else begin
                    tg_d.pre  = tg_q.pre + 1'b1;
                    tg_d.tick = 1'b0;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) tg_q <= '0;
                else         tg_q <= tg_d;
            end

            assign tick_o = tg_q.tick;

            // R3: prescaler never leaves its range
            p_pre_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tg_q.pre <= LAST);
            // R3: ticks are isolated single-cycle pulses
            p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tg_q.tick |=> !tg_q.tick);
        end
    endgenerate
endmodule

// File: rtl/pdf_target.sv
`timescale 1ns/1ps
module pdf_target #(
    parameter int SECS_SHORT = 4,
    parameter int SECS_MID   = 129,
    parameter int SECS_LONG  = 518,
    parameter int CW         = 10
) (
    input  logic [2:0]    code_i,
    output logic [CW-1:0] secs_o
);
    always_comb begin
        unique case (code_i[1:0])
            2'b01:   secs_o = CW'(SECS_SHORT);
            2'b10:   secs_o = CW'(SECS_MID);
            2'b11:   secs_o = CW'(SECS_LONG);
            default: secs_o = '0;
        endcase
        if (code_i[2]) secs_o = '0;
    end
endmodule

// File: rtl/pdf_qualifier.sv
`timescale 1ns/1ps
module pdf_qualifier
    import pdf_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          req_i,
    input  logic [2:0]    code_i,
    input  logic          clr_i,
    input  logic [CW-1:0] target_i,
    output logic          irq_o,
    output logic          busy_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [2:0]    code;
        logic          irq;
        logic          fired;
        logic          busy;
    } qs_t;

    qs_t qs_d, qs_q;
    logic code_same;

    always_comb begin
        qs_d      = qs_q;
        qs_d.code = code_i;
        code_same = (code_i == qs_q.code);
        if (!req_i) begin
            qs_d.cnt   = '0;
            qs_d.irq   = 1'b0;
            qs_d.fired = 1'b0;
        end else begin
            if (!code_same) begin
                qs_d.cnt = '0;
            end else if (is_timed(code_i) && tick_i && (qs_q.cnt < target_i)) begin
                qs_d.cnt = qs_q.cnt + 1'b1;
            end
            if (!qs_q.fired && !clr_i) begin
                if (is_bypass(code_i) ||
                    (is_timed(code_i) && code_same && (qs_q.cnt == target_i))) begin
                    qs_d.irq   = 1'b1;
                    qs_d.fired = 1'b1;
                end
            end
            if (clr_i || (code_i == 3'b000)) qs_d.irq = 1'b0;
        end
        qs_d.busy = req_i && is_timed(code_i) && !qs_d.fired;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) qs_q <= '0;
        else         qs_q <= qs_d;
    end

    assign irq_o  = qs_q.irq;
    assign busy_o = qs_q.busy;

    // R5: bypass code answers on the next edge
    p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && is_bypass(code_i) && !clr_i && !qs_q.fired) |=> irq_o);
    // R3: count never passes the target of its own code
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qs_q.code == code_i) |-> (qs_q.cnt <= target_i));
    // R7: a code change clears the count
    p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_i != qs_q.code) |=> (qs_q.cnt == '0));
    // R8: once cleared, no re-raise while the request holds
    p_no_refire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && req_i && $past(req_i) && irq_o) |=> (!irq_o && qs_q.fired));
endmodule

// File: rtl/pdf_filter_top.sv
`timescale 1ns/1ps
module pdf_filter_top #(
    parameter int TICK_CYCLES = 200_000_000,
    parameter int SECS_SHORT  = 4,
    parameter int SECS_MID    = 129,
    parameter int SECS_LONG   = 518
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pd_req_i,
    input  logic [2:0] filt_code_i,
    input  logic       irq_clr_i,
    output logic       pd_irq_o,
    output logic       pd_busy_o
);
    localparam int MAXS = (SECS_LONG > SECS_MID) ?
                          ((SECS_LONG > SECS_SHORT) ? SECS_LONG : SECS_SHORT) :
                          ((SECS_MID > SECS_SHORT) ? SECS_MID : SECS_SHORT);
    localparam int CW = $clog2(MAXS + 1);

    logic          tick;
    logic [CW-1:0] target;

    pdf_tickgen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    pdf_target #(
        .SECS_SHORT(SECS_SHORT), .SECS_MID(SECS_MID),
        .SECS_LONG(SECS_LONG), .CW(CW)
    ) u_target (
        .code_i (filt_code_i),
        .secs_o (target)
    );

    pdf_qualifier #(.CW(CW)) u_qual (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .req_i    (pd_req_i),
        .code_i   (filt_code_i),
        .clr_i    (irq_clr_i),
        .target_i (target),
        .irq_o    (pd_irq_o),
        .busy_o   (pd_busy_o)
    );

    // R2: disabled code forces the interrupt low
    p_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_code_i == 3'b000) |=> !pd_irq_o);
    // R6: dropped request clears outputs
    p_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pd_req_i |=> (!pd_irq_o && !pd_busy_o));
    // R6: interrupt only rises on a held request
    p_rise_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pd_irq_o) |-> $past(pd_req_i));
    // R8: clear pulse drops the interrupt
    p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_clr_i |=> !pd_irq_o);
    // R9: busy and interrupt are exclusive
    p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pd_busy_o && pd_irq_o));
endmodule

// File: tb/pdf_filter_top_test.sv
`timescale 1ns/1ps
module pdf_filter_top_test;
    localparam int T  = 4;
    localparam int NS = 4;
    localparam int NM = 129;
    localparam int NL = 518;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [2:0] code = 3'b000;
    logic       clr = 1'b0;
    logic       irq, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pdf_filter_top #(
        .TICK_CYCLES(T), .SECS_SHORT(NS), .SECS_MID(NM), .SECS_LONG(NL)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .pd_req_i(req), .filt_code_i(code),
        .irq_clr_i(clr), .pd_irq_o(irq), .pd_busy_o(busy)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int secs_of(input logic [2:0] c);
        return (c == 3'd1) ? NS : (c == 3'd2) ? NM : NL;
    endfunction

    task automatic run_timed(input logic [2:0] c, input int phase);
        int n, lo, hi;
        string tag;
        n   = secs_of(c);
        lo  = (n - 1) * T + 1;
        hi  = n * T + 1;
        tag = (c == 3'd1) ? "R3" : "R4";
        code = c;
        waitn(phase + 2);
        req = 1'b1;
        waitn(1);
        chk("R9 busy after request", busy, 1'b1);
        waitn(lo - 1);
        chk({tag, " early"}, irq, 1'b0);
        chk("R9 busy while counting", busy, 1'b1);
        waitn(hi - lo);
        chk({tag, " due"}, irq, 1'b1);
        chk("R9 busy off at irq", busy, 1'b0);
        clr = 1'b1;
        waitn(1);
        clr = 1'b0;
        chk("R8 cleared", irq, 1'b0);
        waitn(2 * T + 3);
        chk("R8 stays cleared", irq, 1'b0);
        req = 1'b0;
        waitn(1);
        chk("R6 irq off", irq, 1'b0);
        chk("R6 busy off", busy, 1'b0);
        waitn(3);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        waitn(3);
        chk("R1 irq reset", irq, 1'b0);
        chk("R1 busy reset", busy, 1'b0);
        rst_n = 1'b1;
        waitn(2);
        chk("R1 irq idle", irq, 1'b0);

        // R2: disabled code
        for (int ph = 0; ph < 2; ph++) begin
            code = 3'b000;
            waitn(ph + 1);
            req = 1'b1;
            for (int k = 0; k < 6; k++) begin
                waitn(8);
                chk("R2 irq off", irq, 1'b0);
                chk("R2 busy off", busy, 1'b0);
            end
            req = 1'b0;
            waitn(2);
        end

        // R3/R4: timed codes across all tick phases
        for (int c = 1; c < 4; c++)
            for (int ph = 0; ph < T; ph++)
                run_timed(3'(c), ph);

        // R5: bypass codes
        for (int c = 4; c < 8; c++) begin
            for (int ph = 0; ph < 2; ph++) begin
                code = 3'(c);
                waitn(ph + 1);
                req = 1'b1;
                waitn(1);
                chk("R5 immediate", irq, 1'b1);
                chk("R9 no busy in bypass", busy, 1'b0);
                clr = 1'b1;
                waitn(1);
                clr = 1'b0;
                chk("R8 bypass cleared", irq, 1'b0);
                waitn(3);
                chk("R8 bypass no refire", irq, 1'b0);
                req = 1'b0;
                waitn(1);
                chk("R6 bypass drop", irq, 1'b0);
                waitn(2);
            end
        end

        // R6: interrupted request restarts the count
        code = 3'd1;
        waitn(2);
        req = 1'b1;
        waitn(3 * T);
        chk("R6 not yet", irq, 1'b0);
        req = 1'b0;
        waitn(2);
        req = 1'b1;
        waitn((NS - 1) * T + 1);
        chk("R6 restarted early", irq, 1'b0);
        waitn(T);
        chk("R6 restarted due", irq, 1'b1);
        req = 1'b0;
        waitn(1);
        chk("R6 drop clears irq", irq, 1'b0);
        waitn(3);

        // R7: code change mid-count restarts under new code
        code = 3'd2;
        waitn(2);
        req = 1'b1;
        waitn(20 * T);
        chk("R7 mid count", irq, 1'b0);
        code = 3'd1;
        waitn((NS - 1) * T + 1);
        chk("R7 early", irq, 1'b0);
        chk("R7 busy", busy, 1'b1);
        waitn(T + 1);
        chk("R7 due", irq, 1'b1);
        req = 1'b0;
        waitn(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule